// File: doc/BRIEF.md
# GPIO Port with Weak Pull-Up Control

This block controls a parameterised general-purpose I/O port (eight pins by default). Software writes a direction register and an output data register over a simple synchronous write bus. The block turns these into per-pin output enables and output levels. It samples the pin inputs through a synchronizer so that a pin-level register can be read back. For every pin it also produces a weak pull-up enable. The output data register does a second job here: on a pin set as input, a 1 in that pin's data bit turns its pull-up on.

The pull-up enables react to two power states. Hardware standby forces every pull-up off. Software standby freezes each pull-up at the value it had on the last cycle before standby began, whatever is written to the registers meanwhile.

Pin 0 can also be routed to two peripherals. It becomes the slave-select input of a serial port when three mode bits of that port are all set. It can also feed a key-interrupt input while the key mask is clear and the pin is an input.

Top module: `gpio_pullup_port`

## Requirements
- R1: After reset the direction and output data registers are all zeros, all output enables are 0 and all pull-up enables are 0.
- R2: A write with `wr_en` high stores `wr_data` on the next rising clock edge. Address 0 selects the direction register (1 = output) and address 1 selects the output data register. `rd_data` returns the stored value combinationally for the same addresses.
- R3: Outside both standby states, `pull_en[i]` is 1 exactly when direction bit i is 0 and output data bit i is 1.
- R4: While `hw_stby` is 1, every bit of `pull_en` is 0, whatever the register contents and whatever `sw_stby` is.
- R5: While `sw_stby` is 1 (and `hw_stby` is 0), `pull_en` keeps the value it had in the last cycle before `sw_stby` rose, even when the registers are written.
- R6: Once `sw_stby` returns to 0, `pull_en` follows the rule of R3 again from the current register contents.
- R7: Pin 0 is claimed by the serial port when `ser_sel_en`, `ser_sync_mode` and `ser_ext_clk` are all 1. While pin 0 is claimed, `pin_oe[0]` and `pin_out[0]` are 0 and `ser_sel_in` equals the synchronized level of pin 0. Otherwise `ser_sel_in` is 1.
- R8: Outside the serial claim, `pin_oe[i]` equals direction bit i and `pin_out[i]` equals output data bit i, for every pin including pin 0.
- R9: `key_pin` equals the synchronized level of pin 0 while `key_mask` is 0 and direction bit 0 is 0. In every other case `key_pin` is 1.
- R10: A change on `pin_in` becomes visible on the read path and on the routed outputs after two rising clock edges, and not before.
- R11: Address 2 reads the pin-level register. Bit i is output data bit i when `pin_oe[i]` is 1, and otherwise the synchronized level of pin i. Writes to address 2 are ignored.
- R12: Address 3 reads as zero, and a write to it changes neither the direction nor the output data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_stby | input | 1 | Hardware standby: forces all pull-ups off |
| sw_stby | input | 1 | Software standby: freezes pull-up state |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | WIDTH | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | WIDTH | Register read data (combinational) |
| pin_in | input | WIDTH | Asynchronous pin levels |
| pin_oe | output | WIDTH | Per-pin output enable |
| pin_out | output | WIDTH | Per-pin output level |
| pull_en | output | WIDTH | Per-pin weak pull-up enable |
| ser_sel_en | input | 1 | Serial port slave-select enable mode bit |
| ser_sync_mode | input | 1 | Serial port is in clocked synchronous mode |
| ser_ext_clk | input | 1 | Serial port takes an external clock |
| key_mask | input | 1 | Key-interrupt mask for pin 0 (1 = masked) |
| key_pin | output | 1 | Pin 0 level routed to the key-interrupt logic |
| ser_sel_in | output | 1 | Pin 0 level routed to the serial port slave-select |

## Verification
The bench targets the cycle in which software standby begins while a register write lands on the same edge. A design that samples the pull-up state one cycle late, or from the new register values, freezes the wrong pattern. Hardware standby is raised together with software standby, to catch a priority that lets the held value leak through. The bench also runs through every combination of the three serial mode bits with pin 0 set as an output: a design that decodes only part of the claim drives the pin while the serial port expects to read it, or stops driving it when it should. Pin toggles are timed to show whether the synchronizer has one stage too few or too many, and writes to addresses 2 and 3 show whether an unused address corrupts a register.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   localparam int REG_ADDR_W = 2;

   typedef enum logic [REG_ADDR_W-1:0] {
      REG_DIR  = 2'd0,
      REG_DATA = 2'd1,
      REG_PINS = 2'd2,
      REG_NONE = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[0] <= '0;
      else        stage_q[0] <= async_in;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[s] <= '0;
         else        stage_q[s] <= stage_q[s-1];
      end
   end

   assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_port_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [REG_ADDR_W-1:0] wr_addr,
   input  logic [WIDTH-1:0]      wr_data,
   input  logic [REG_ADDR_W-1:0] rd_addr,
   input  logic [WIDTH-1:0]      pin_lvl,
   input  logic [WIDTH-1:0]      eff_oe,
   output logic [WIDTH-1:0]      dir_q,
   output logic [WIDTH-1:0]      odr_q,
   output logic [WIDTH-1:0]      rd_data
);
   reg_sel_e         wsel, rsel;
   logic [WIDTH-1:0] pins_view;

   assign wsel = reg_sel_e'(wr_addr);
   assign rsel = reg_sel_e'(rd_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '0;
         odr_q <= '0;
      end else if (wr_en) begin
         if (wsel == REG_DIR)  dir_q <= wr_data;
         if (wsel == REG_DATA) odr_q <= wr_data;
      end
   end

   assign pins_view = (eff_oe & odr_q) | (~eff_oe & pin_lvl);

   always_comb begin
      unique case (rsel)
         REG_DIR:  rd_data = dir_q;
         REG_DATA: rd_data = odr_q;
         REG_PINS: rd_data = pins_view;
         default:  rd_data = '0;
      endcase
   end
endmodule

// File: rtl/gpio_pull_ctl.sv
module gpio_pull_ctl #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hw_stby,
   input  logic             sw_stby,
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] odr_q,
   output logic [WIDTH-1:0] pull_en
);
   logic [WIDTH-1:0] live;
   logic [WIDTH-1:0] held_q;

   assign live = ~dir_q & odr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        held_q <= '0;
      else if (hw_stby)  held_q <= '0;
      else if (!sw_stby) held_q <= live;
   end

   always_comb begin
      if (hw_stby)      pull_en = '0;
      else if (sw_stby) pull_en = held_q;
      else              pull_en = live;
   end
endmodule

// File: rtl/gpio_pin0_route.sv
module gpio_pin0_route (
   input  logic dir0,
   input  logic odr0,
   input  logic sync0,
   input  logic ser_sel_en,
   input  logic ser_sync_mode,
   input  logic ser_ext_clk,
   input  logic key_mask,
   output logic oe0,
   output logic out0,
   output logic key_pin,
   output logic ser_sel_in
);
   logic claim;

   assign claim      = ser_sel_en & ser_sync_mode & ser_ext_clk;
   assign oe0        = claim ? 1'b0 : dir0;
   assign out0       = claim ? 1'b0 : odr0;
   assign ser_sel_in = claim ? sync0 : 1'b1;
   assign key_pin    = (!key_mask && !dir0) ? sync0 : 1'b1;
endmodule

// File: rtl/gpio_pullup_port.sv
module gpio_pullup_port
   import gpio_port_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  hw_stby,
   input  logic                  sw_stby,
   input  logic                  wr_en,
   input  logic [REG_ADDR_W-1:0] wr_addr,
   input  logic [WIDTH-1:0]      wr_data,
   input  logic [REG_ADDR_W-1:0] rd_addr,
   output logic [WIDTH-1:0]      rd_data,
   input  logic [WIDTH-1:0]      pin_in,
   output logic [WIDTH-1:0]      pin_oe,
   output logic [WIDTH-1:0]      pin_out,
   output logic [WIDTH-1:0]      pull_en,
   input  logic                  ser_sel_en,
   input  logic                  ser_sync_mode,
   input  logic                  ser_ext_clk,
   input  logic                  key_mask,
   output logic                  key_pin,
   output logic                  ser_sel_in
);
   localparam int UPPER = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("gpio_pullup_port: WIDTH must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_pullup_port: SYNC_STAGES must be at least 2");
   end

   logic [WIDTH-1:0] pin_sync;
   logic [WIDTH-1:0] dir_q, odr_q;
   logic             oe0, out0;

   gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pin_in),
      .sync_out (pin_sync)
   );

   gpio_regs #(.WIDTH(WIDTH)) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .pin_lvl (pin_sync),
      .eff_oe  (pin_oe),
      .dir_q   (dir_q),
      .odr_q   (odr_q),
      .rd_data (rd_data)
   );

   gpio_pull_ctl #(.WIDTH(WIDTH)) i_pull (
      .clk     (clk),
      .rst_n   (rst_n),
      .hw_stby (hw_stby),
      .sw_stby (sw_stby),
      .dir_q   (dir_q),
      .odr_q   (odr_q),
      .pull_en (pull_en)
   );

   gpio_pin0_route i_pin0 (
      .dir0          (dir_q[0]),
      .odr0          (odr_q[0]),
      .sync0         (pin_sync[0]),
      .ser_sel_en    (ser_sel_en),
      .ser_sync_mode (ser_sync_mode),
      .ser_ext_clk   (ser_ext_clk),
      .key_mask      (key_mask),
      .oe0           (oe0),
      .out0          (out0),
      .key_pin       (key_pin),
      .ser_sel_in    (ser_sel_in)
   );

   assign pin_oe  = {dir_q[UPPER:1], oe0};
   assign pin_out = {odr_q[UPPER:1], out0};
endmodule

// File: rtl/gpio_pullup_port_chk.sv
module gpio_pullup_port_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hw_stby,
   input logic             sw_stby,
   input logic [WIDTH-1:0] pin_oe,
   input logic [WIDTH-1:0] pin_out,
   input logic [WIDTH-1:0] pull_en,
   input logic             ser_sel_en,
   input logic             ser_sync_mode,
   input logic             ser_ext_clk,
   input logic             key_mask,
   input logic             key_pin,
   input logic             ser_sel_in
);
   logic claim;
   assign claim = ser_sel_en & ser_sync_mode & ser_ext_clk;

   AST_HW_STBY_PULL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      hw_stby |-> (pull_en == '0)); // R4

   AST_NO_PULL_ON_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (!hw_stby && !sw_stby) |-> ((pull_en & pin_oe) == '0)); // R3

   AST_SW_STBY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_stby && $past(sw_stby) && !hw_stby && !$past(hw_stby)) |-> $stable(pull_en)); // R5

   AST_CLAIM_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      claim |-> (!pin_oe[0] && !pin_out[0])); // R7

   AST_UNCLAIMED_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !claim |-> ser_sel_in); // R7

   AST_MASKED_KEY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      key_mask |-> key_pin); // R9
endmodule

bind gpio_pullup_port gpio_pullup_port_chk #(.WIDTH(WIDTH)) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .hw_stby       (hw_stby),
   .sw_stby       (sw_stby),
   .pin_oe        (pin_oe),
   .pin_out       (pin_out),
   .pull_en       (pull_en),
   .ser_sel_en    (ser_sel_en),
   .ser_sync_mode (ser_sync_mode),
   .ser_ext_clk   (ser_ext_clk),
   .key_mask      (key_mask),
   .key_pin       (key_pin),
   .ser_sel_in    (ser_sel_in)
);

// File: tb/test_gpio_pullup_port.sv
`timescale 1ns/1ps
module test_gpio_pullup_port;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         hw_stby = 1'b0, sw_stby = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_addr = '0, rd_addr = '0;
   logic [W-1:0] wr_data = '0, pin_in = '0;
   logic [W-1:0] rd_data, pin_oe, pin_out, pull_en;
   logic         ser_sel_en = 1'b0, ser_sync_mode = 1'b0, ser_ext_clk = 1'b0;
   logic         key_mask = 1'b1;
   logic         key_pin, ser_sel_in;

   int    n_chk = 0, n_err = 0, cyc = 0;
   string cur_req = "R1";

   // reference state
   logic [W-1:0] m_dir = '0, m_odr = '0, m_held = '0, m_s1 = '0, m_s2 = '0;

   always #5 clk = ~clk;

   gpio_pullup_port #(.WIDTH(W), .SYNC_STAGES(2)) i_gpio_pullup_port (
      .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .pull_en(pull_en),
      .ser_sel_en(ser_sel_en), .ser_sync_mode(ser_sync_mode), .ser_ext_clk(ser_ext_clk),
      .key_mask(key_mask), .key_pin(key_pin), .ser_sel_in(ser_sel_in)
   );

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", cur_req, what, act, exp, cyc);
      end
   endtask

   task automatic compare_all();
      logic [W-1:0] e_oe, e_out, e_pull, e_rd, pins;
      logic         claim, e_sel, e_key;
      claim = ser_sel_en && ser_sync_mode && ser_ext_clk;
      for (int i = 0; i < W; i++) begin
         e_oe[i]  = m_dir[i];
         e_out[i] = m_odr[i];
         if (i == 0 && claim) begin
            e_oe[i]  = 1'b0;
            e_out[i] = 1'b0;
         end
         if (hw_stby)      e_pull[i] = 1'b0;
         else if (sw_stby) e_pull[i] = m_held[i];
         else              e_pull[i] = !m_dir[i] && m_odr[i];
         pins[i] = e_oe[i] ? m_odr[i] : m_s2[i];
      end
      e_sel = claim ? m_s2[0] : 1'b1;
      e_key = (!key_mask && !m_dir[0]) ? m_s2[0] : 1'b1;
      case (rd_addr)
         2'd0:    e_rd = m_dir;
         2'd1:    e_rd = m_odr;
         2'd2:    e_rd = pins;
         default: e_rd = '0;
      endcase
      chk("pin_oe",     32'(pin_oe),     32'(e_oe));
      chk("pin_out",    32'(pin_out),    32'(e_out));
      chk("pull_en",    32'(pull_en),    32'(e_pull));
      chk("rd_data",    32'(rd_data),    32'(e_rd));
      chk("ser_sel_in", 32'(ser_sel_in), 32'(e_sel));
      chk("key_pin",    32'(key_pin),    32'(e_key));
   endtask

   // reference model, updated on every edge, compared 2 ns later
   always @(posedge clk) begin
      logic [W-1:0] live_old;
      cyc++;
      if (!rst_n) begin
         m_dir = '0; m_odr = '0; m_held = '0; m_s1 = '0; m_s2 = '0;
      end else begin
         for (int i = 0; i < W; i++) live_old[i] = !m_dir[i] && m_odr[i];
         if (hw_stby)      m_held = '0;
         else if (!sw_stby) m_held = live_old;
         m_s2 = m_s1;
         m_s1 = pin_in;
         if (wr_en) begin
            if (wr_addr == 2'd0) m_dir = wr_data;
            if (wr_addr == 2'd1) m_odr = wr_data;
         end
      end
      #2;
      compare_all();
      if (cyc > 20000) begin
         n_err++;
         $display("FAIL watchdog: actual cycle %0d expected below 20000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      tick(1);
      wr_en = 1'b0;
   endtask

   initial begin
      cur_req = "R1";
      tick(3);
      rst_n = 1'b1;
      for (int a = 0; a < 4; a++) begin rd_addr = 2'(a); tick(1); end

      cur_req = "R2";
      wr(2'd0, 8'hF0); rd_addr = 2'd0; tick(1);
      wr(2'd1, 8'hAA); rd_addr = 2'd1; tick(1);

      cur_req = "R3";
      wr(2'd0, 8'h0F); wr(2'd1, 8'h3C); tick(2);
      wr(2'd0, 8'h00); wr(2'd1, 8'hFF); tick(2);

      cur_req = "R10";
      rd_addr = 2'd2; wr(2'd0, 8'h00);
      pin_in = 8'h5A; tick(1); pin_in = 8'hA5; tick(1); pin_in = 8'hFF; tick(3);

      cur_req = "R11";
      wr(2'd0, 8'hC3); wr(2'd1, 8'h81); pin_in = 8'h3C; tick(3);
      pin_in = 8'hC3; tick(3);
      wr(2'd2, 8'h55); rd_addr = 2'd0; tick(1); rd_addr = 2'd1; tick(1);

      cur_req = "R12";
      wr(2'd3, 8'hFF); rd_addr = 2'd3; tick(1); rd_addr = 2'd0; tick(1); rd_addr = 2'd1; tick(1);

      cur_req = "R4";
      wr(2'd0, 8'h0F); wr(2'd1, 8'hFF);
      hw_stby = 1'b1; tick(2); wr(2'd0, 8'h00); tick(1);
      sw_stby = 1'b1; tick(2); hw_stby = 1'b0; tick(2); sw_stby = 1'b0; tick(2);

      cur_req = "R5";
      wr(2'd0, 8'h00); wr(2'd1, 8'h66); tick(1);
      // sw standby begins on the same edge as a write
      sw_stby = 1'b1; wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h99; tick(1); wr_en = 1'b0;
      wr(2'd0, 8'hFF); wr(2'd1, 8'h00); tick(3);

      cur_req = "R6";
      sw_stby = 1'b0; tick(1); wr(2'd0, 8'h0F); wr(2'd1, 8'hF3); tick(2);

      cur_req = "R7";
      wr(2'd0, 8'h01); wr(2'd1, 8'h01);
      for (int m = 0; m < 8; m++) begin
         {ser_sel_en, ser_sync_mode, ser_ext_clk} = 3'(m);
         pin_in[0] = 1'b0; tick(3); pin_in[0] = 1'b1; tick(3);
      end

      cur_req = "R8";
      {ser_sel_en, ser_sync_mode, ser_ext_clk} = 3'b110;
      wr(2'd0, 8'hFE); wr(2'd1, 8'h5B); tick(1); wr(2'd0, 8'h01); tick(1);
      {ser_sel_en, ser_sync_mode, ser_ext_clk} = 3'b000;

      cur_req = "R9";
      for (int m = 0; m < 4; m++) begin
         key_mask = m[0]; wr(2'd0, {7'd0, m[1]});
         pin_in[0] = 1'b0; tick(3); pin_in[0] = 1'b1; tick(3);
      end
      key_mask = 1'b1;

      cur_req = "R3";
      for (int k = 0; k < 300; k++) begin
         wr_en = 1'(($urandom % 4) != 0); wr_addr = 2'($urandom);
         wr_data = 8'($urandom); rd_addr = 2'($urandom); pin_in = 8'($urandom);
         key_mask = 1'($urandom); {ser_sel_en, ser_sync_mode, ser_ext_clk} = 3'($urandom);
         hw_stby = 1'(($urandom % 8) == 0); sw_stby = 1'(($urandom % 4) == 0);
         tick(1);
      end
      wr_en = 1'b0;

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule